// File: doc/BRIEF.md
# Supply-Supervised Reset Pulse Generator

This block produces the reset for a processor from two sources. The first is a flag, already synchronised to the clock, that an external comparator raises while the supply sits below its threshold. The second is an active-low manual request, which may come from a pushbutton or from another block's logic output, such as a watchdog timeout. Reset stays asserted for as long as either source is active. After the last active source goes away, a stretch counter keeps reset asserted for a further parameterised number of clock cycles and then releases it.

A supply dip during a pulse reloads the full nominal stretch. A manual request reloads the counter to at least the minimum width, but never shortens a longer stretch that is already running. That minimum width is the only debounce a bouncing pushbutton gets. The counter reloads on every trigger; it does not add to its count.

Reset is driven as an active-low signal and as its active-high complement. Each comes from its own flip-flop. A power-on-clear input puts the block into the asserted state at once. Its release is passed through a two-stage synchroniser before the stretch begins.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `por_n` is low, `rst_n_o` is 0 and `rst_o` is 1. After `por_n` rises, `rst_n_o` rises on the (RESET_CYCLES+2)-th rising clock edge, provided no trigger is active. The two extra edges come from the release synchroniser.
- R2: On every clock cycle that follows a rising edge at which `supply_low` was sampled 1, `rst_n_o` is 0.
- R3: When `supply_low` was 1 at a rising edge and no trigger is sampled after it, `rst_n_o` rises exactly RESET_CYCLES rising edges later.
- R4: A pulse of `supply_low` at any point during an ongoing stretch reloads the counter to RESET_CYCLES. Release then follows exactly RESET_CYCLES edges after the last high sample, whatever count remained.
- R5: `rst_o` equals the inverse of `rst_n_o` on every cycle.
- R6: On every cycle that follows a rising edge at which `mr_n` was sampled 0, `rst_n_o` is 0. The stretch does not count down while `mr_n` stays 0.
- R7: After the last edge at which `mr_n` is sampled 0 (with `supply_low` 0), release comes max(remaining, MIN_CYCLES) edges later. Here remaining is the count left in the stretch just before that edge, and it is 0 if reset was already released. A manual request never shortens a stretch.
- R8: A bouncing manual input, made of low samples separated by gaps shorter than MIN_CYCLES, keeps reset asserted without a break. Release comes MIN_CYCLES edges after the last low sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on-clear, asynchronous assert, active low |
| supply_low | input | 1 | Synchronised supply-below-threshold flag, active high |
| mr_n | input | 1 | Manual reset request, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high, complement of `rst_n_o` |

## Verification
The checker verifies several properties on every cycle. Reset follows any sampled supply-low or manual request on the next cycle. The two outputs stay complementary. No release ever comes earlier than MIN_CYCLES after the last trigger. The exact release instant cannot be expressed as a per-cycle property, because it depends on the remaining count and on which source fired last. The bench therefore sweeps the point of a supply dip and of a manual press across a whole stretch, drives bounce patterns with every sub-minimum gap, and compares each measured release delay against a delay it computes arithmetically.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

  // Width of a counter that must hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rpg_rst_sync.sv
module rpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rpg_trigger.sv
module rpg_trigger #(
  parameter int unsigned CW           = 4,
  parameter int unsigned RESET_CYCLES = 10,
  parameter int unsigned MIN_CYCLES   = 7
) (
  input  logic          supply_low,
  input  logic          mr_n,
  input  logic [CW-1:0] cnt_q,
  output logic          trig,
  output logic [CW-1:0] load_val
);

  localparam logic [CW-1:0] NOMINAL = CW'(RESET_CYCLES);
  localparam logic [CW-1:0] MINIMUM = CW'(MIN_CYCLES);

  logic manual_req;

  assign manual_req = ~mr_n;

  always_comb begin
    trig     = supply_low | manual_req;
    load_val = cnt_q;
    if (supply_low) begin
      // supply event: full nominal stretch
      load_val = NOMINAL;
    end else if (manual_req) begin
      // manual event: at least the minimum, never shorter than what runs
      load_val = (cnt_q > MINIMUM) ? cnt_q : MINIMUM;
    end
  end

endmodule

// File: rtl/rpg_stretch.sv
module rpg_stretch #(
  parameter int unsigned CW           = 4,
  parameter int unsigned RESET_CYCLES = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_q,
  output logic          active_d
);

  localparam logic [CW-1:0] NOMINAL = CW'(RESET_CYCLES);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (trig) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    active_d = trig | (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= NOMINAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rpg_out_stage.sv
module rpg_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic active_d,
  output logic rst_n_o,
  output logic rst_o
);

  logic lo_q;
  logic hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b1;
    end else begin
      lo_q <= ~active_d;
      hi_q <= active_d;
    end
  end

  assign rst_n_o = lo_q;
  assign rst_o   = hi_q;

endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned RESET_CYCLES = 10_000_000,
  parameter int unsigned MIN_CYCLES   = 7_000_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low,
  input  logic mr_n,
  output logic rst_n_o,
  output logic rst_o
);

  localparam int unsigned CW = rpg_pkg::cnt_width(RESET_CYCLES);

  logic          rst_int_n;
  logic          trig;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt_q;
  logic          active_d;

  rpg_rst_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (rst_int_n)
  );

  rpg_trigger #(
    .CW           (CW),
    .RESET_CYCLES (RESET_CYCLES),
    .MIN_CYCLES   (MIN_CYCLES)
  ) u_trig (
    .supply_low (supply_low),
    .mr_n       (mr_n),
    .cnt_q      (cnt_q),
    .trig       (trig),
    .load_val   (load_val)
  );

  rpg_stretch #(
    .CW           (CW),
    .RESET_CYCLES (RESET_CYCLES)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .trig     (trig),
    .load_val (load_val),
    .cnt_q    (cnt_q),
    .active_d (active_d)
  );

  rpg_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .active_d (active_d),
    .rst_n_o  (rst_n_o),
    .rst_o    (rst_o)
  );

endmodule

// File: rtl/rpg_checker.sv
module rpg_checker #(
  parameter int unsigned RESET_CYCLES = 10,
  parameter int unsigned MIN_CYCLES   = 7
) (
  input logic clk,
  input logic por_n,
  input logic supply_low,
  input logic mr_n,
  input logic rst_n_o,
  input logic rst_o
);

  localparam int unsigned QW = rpg_pkg::cnt_width(RESET_CYCLES) + 1;
  localparam logic [QW-1:0] QMAX = '1;

  // cycles since the last sampled trigger, saturating
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      quiet_q <= '0;
    end else if (supply_low || !mr_n) begin
      quiet_q <= '0;
    end else if (quiet_q != QMAX) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  // R2: a sampled supply-low asserts reset on the following cycle
  a_r2_supply_holds: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> !rst_n_o);

  // R6: a sampled manual request asserts reset on the following cycle
  a_r6_manual_holds: assert property (@(posedge clk) disable iff (!por_n)
    !mr_n |=> !rst_n_o);

  // R5: outputs are complementary on every cycle
  a_r5_complement: assert property (@(posedge clk) disable iff (!por_n)
    rst_o == !rst_n_o);

  // R7: no release earlier than the minimum width after the last trigger
  a_r7_min_width: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n_o) |-> (quiet_q >= QW'(MIN_CYCLES)));

endmodule

bind rst_pulse_gen rpg_checker #(
  .RESET_CYCLES (RESET_CYCLES),
  .MIN_CYCLES   (MIN_CYCLES)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .supply_low (supply_low),
  .mr_n       (mr_n),
  .rst_n_o    (rst_n_o),
  .rst_o      (rst_o)
);

// File: tb/tb_rst_pulse_gen.sv
module tb_rst_pulse_gen;

  localparam int RC = 20;
  localparam int MC = 8;
  localparam int LIMIT = 200;

  logic clk;
  logic por_n;
  logic supply_low;
  logic mr_n;
  logic rst_n_o;
  logic rst_o;

  int vectors;
  int miscompares;
  bit done;

  rst_pulse_gen #(.RESET_CYCLES(RC), .MIN_CYCLES(MC)) dut (
    .clk        (clk),
    .por_n      (por_n),
    .supply_low (supply_low),
    .mr_n       (mr_n),
    .rst_n_o    (rst_n_o),
    .rst_o      (rst_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // R5: complement checked at every falling edge
  always @(negedge clk) begin
    if (!done) chk(rst_o == ~rst_n_o, "R5 complement", int'(rst_o), int'(~rst_n_o));
  end

  // counts falling edges until rst_n_o is high
  task automatic measure(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!rst_n_o && k < LIMIT);
  endtask

  task automatic hold_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rst_n_o == 1'b0, req, int'(rst_n_o), 0);
    end
  endtask

  task automatic supply_pulse();
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
  endtask

  initial begin
    int k;
    int exp;
    vectors = 0;
    miscompares = 0;
    done = 1'b0;
    por_n = 1'b0;
    supply_low = 1'b0;
    mr_n = 1'b1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rst_n_o == 1'b0, "R1 reset rst_n_o", int'(rst_n_o), 0);
    chk(rst_o == 1'b1, "R1 reset rst_o", int'(rst_o), 1);
    por_n = 1'b1;
    measure(k);
    chk(k == RC + 2, "R1 power-on release delay", k, RC + 2);

    // R2 and R3: held supply-low, then nominal stretch
    supply_low = 1'b1;
    hold_check(30, "R2 held during supply low");
    supply_low = 1'b0;
    measure(k);
    chk(k == RC, "R3 nominal release delay", k, RC);

    // R4: dip swept across the whole stretch
    for (int d = 0; d <= RC + 2; d++) begin
      supply_pulse();
      repeat (d) @(negedge clk);
      supply_pulse();
      measure(k);
      chk(k == RC, "R4 dip reload", k, RC);
    end

    // R7: manual press swept across the stretch
    for (int d = 0; d <= RC + 2; d++) begin
      supply_pulse();
      repeat (d) @(negedge clk);
      mr_n = 1'b0;
      @(negedge clk);
      mr_n = 1'b1;
      exp = (RC - d > MC) ? RC - d : MC;
      measure(k);
      chk(k == exp, "R7 manual press never shortens", k, exp);
    end

    // R6: manual held, stretch starts on release
    mr_n = 1'b0;
    hold_check(40, "R6 held during manual");
    mr_n = 1'b1;
    measure(k);
    chk(k == MC, "R6 release after manual hold", k, MC);

    // R8: bounce with every gap shorter than the minimum
    for (int g = 1; g < MC; g++) begin
      mr_n = 1'b0;
      @(negedge clk);
      mr_n = 1'b1;
      hold_check(g, "R8 no break during bounce");
      mr_n = 1'b0;
      @(negedge clk);
      mr_n = 1'b1;
      hold_check(g, "R8 no break during bounce");
      mr_n = 1'b0;
      @(negedge clk);
      mr_n = 1'b1;
      measure(k);
      chk(k == MC, "R8 release after bounce", k, MC);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule